// File: doc/BRIEF.md
# Two-Phase Stepper Microstep Translator

This block turns a step clock into coil current targets for a two-phase stepper motor. It keeps an electrical position of 64 steps per cycle, with four quadrants of 16 sub-steps. Each rising edge of the step input moves the position forward or backward. The distance moved depends on the resolution selected at that edge: full, half, quarter, eighth or sixteenth step. For each phase, the block outputs a polarity bit and a 4-bit current-ratio code. A downstream current regulator turns these into coil current.

The step, direction and mode inputs come from another clock domain, so they pass through a synchronizer first. The position moves only on a rising edge of the synchronized step input. Two full-step and two half-step patterns are available. One full-step pattern holds both coils at the 70.7% level. The others either follow the sine and cosine tables or force every active coil to full current. One mode code places the translator in standby, and step edges are then dropped. A monitor bit goes high when both coils are at the 70.7% code. A build parameter selects the microstep translator or a full/half-only translator, in which every code with the top mode bit set means standby.

Top module: `step_translator`

## Requirements
- R1: Reset is asynchronous and active high. It sets the position index to 0 and the active pattern to half step (`010`). The outputs then read polA=0, codeA=15, polB=0, codeB=0, twoPhase=0.
- R2: Only a rising edge of the synchronized stepIn moves the position, and each edge moves it exactly once. Holding stepIn high gives no further moves. The outputs settle within SYNC_STAGES+2 clock edges of the input rise.
- R3: dirIn=0 at the step edge moves the index up (forward). dirIn=1 moves it down (reverse). The index wraps modulo 64.
- R4: modeIn bit 0 is M1, bit 1 is M2 and bit 2 is M3. The encodings are: `000` full step at coil centres, `001` full step at full current, `010` half step, `011` half step at full current, `100` quarter step, `101` eighth step, `110` sixteenth step, `111` standby. The index strides are 16, 16, 8, 8, 4, 2 and 1.
- R5: Let q be the index divided by 16 and k the index modulo 16. The rising code is k. The falling code is 16-k, or 15 when k=0. For even q, codeA is the falling code and codeB the rising code. For odd q, they swap. Code n stands for about sin(n·5.625°) of full current, with 15 meaning 100%.
- R6: polA is 1 in quadrants 1 and 2. polB is 1 in quadrants 2 and 3.
- R7: In the full-current patterns (`001`, `011`), every nonzero code reads 15.
- R8: twoPhase is high exactly when codeA and codeB are both 8.
- R9: In standby, step edges are dropped. The index and the active pattern hold.
- R10: A change of modeIn or dirIn with no step edge leaves every output unchanged. The new values are sampled at the next step edge.
- R11: When the index is off the new mode's grid, a forward step moves it to the next grid point above. A reverse step moves it to the grid point below. In the centred full-step pattern, the index snaps down to its quadrant start and moves a whole quadrant. The outputs show the quadrant centre (k=8).
- R12: With MICRO_EN=0, codes `100` to `111` all mean standby.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Asynchronous active-high reset |
| stepIn | input | 1 | Step clock; the rising edge moves the position |
| dirIn | input | 1 | 0 forward, 1 reverse |
| modeIn | input | 3 | Resolution and pattern select, bit 0 = M1 |
| polA | output | 1 | Phase A polarity, 1 = negative |
| codeA | output | 4 | Phase A current-ratio code |
| polB | output | 1 | Phase B polarity, 1 = negative |
| codeB | output | 4 | Phase B current-ratio code |
| twoPhase | output | 1 | Both phases at code 8 |

## Verification
Some properties are checked on every cycle. Each step edge gives a one-cycle strobe. The position and active pattern move only on that strobe, and every strobe does move the position. No strobe is issued in standby. A zero code on phase A always pairs with code 15 on phase B. The monitor bit never rises in a full-current pattern. Other behaviour can only be shown by the bench scenarios: the exact stride and rounding per mode, the polarity per quadrant, dropped edges in standby, mode changes without an edge, async reset in mid-run, and the reduced build.

// File: rtl/stepx_pkg.sv
package stepx_pkg;
  localparam int QUAD_W = 4;
  localparam int CODE_W = 4;
  localparam int POS_W  = QUAD_W + 2;
  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    MD_FULL_MID  = 3'b000,
    MD_FULL_MAX  = 3'b001,
    MD_HALF      = 3'b010,
    MD_HALF_MAX  = 3'b011,
    MD_QUARTER   = 3'b100,
    MD_EIGHTH    = 3'b101,
    MD_SIXTEENTH = 3'b110,
    MD_STANDBY   = 3'b111
  } stepMode_e;

  typedef struct packed {
    logic      stepEn;
    logic      dirRev;
    stepMode_e mode;
  } stepStrobe_t;

  function automatic logic [2:0] strideShift(input stepMode_e m);
    case (m)
      MD_FULL_MID, MD_FULL_MAX: strideShift = 3'd4;
      MD_HALF, MD_HALF_MAX:     strideShift = 3'd3;
      MD_QUARTER:               strideShift = 3'd2;
      MD_EIGHTH:                strideShift = 3'd1;
      default:                  strideShift = 3'd0;
    endcase
  endfunction

  function automatic logic isMaxHold(input stepMode_e m);
    isMaxHold = (m == MD_FULL_MAX) || (m == MD_HALF_MAX);
  endfunction
endpackage

// File: rtl/stepx_ctrl.sv
module stepx_ctrl
  import stepx_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter bit MICRO_EN    = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stepIn,
  input  logic              dirIn,
  input  logic [MODE_W-1:0] modeIn,
  output stepStrobe_t       strb
);
  localparam int BUS_W = MODE_W + 2;

  logic [BUS_W-1:0] rawBus;
  logic [BUS_W-1:0] chain [SYNC_STAGES];
  logic             syncStep, syncDir, stepPrev, stepRise, standby;
  stepMode_e        syncMode;

  assign rawBus = {stepIn, dirIn, modeIn};

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      for (int i = 0; i < SYNC_STAGES; i++) chain[i] <= '0;
    end else begin
      chain[0] <= rawBus;
      for (int i = 1; i < SYNC_STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign syncStep = chain[SYNC_STAGES-1][BUS_W-1];
  assign syncDir  = chain[SYNC_STAGES-1][BUS_W-2];
  assign syncMode = stepMode_e'(chain[SYNC_STAGES-1][MODE_W-1:0]);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) stepPrev <= 1'b0;
    else     stepPrev <= syncStep;
  end

  assign stepRise = syncStep & ~stepPrev;

  generate
    if (MICRO_EN) begin : g_micro
      assign standby = (syncMode == MD_STANDBY);
    end else begin : g_fullhalf
      assign standby = syncMode[MODE_W-1];
    end
  endgenerate

  always_comb begin
    strb.stepEn = stepRise & ~standby;
    strb.dirRev = syncDir;
    strb.mode   = syncMode;
  end

  // R2: one strobe per synchronized rising edge
  p_single_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    strb.stepEn |=> !strb.stepEn);
endmodule

// File: rtl/stepx_datapath.sv
module stepx_datapath
  import stepx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  stepStrobe_t       strb,
  output logic              polA,
  output logic [CODE_W-1:0] codeA,
  output logic              polB,
  output logic [CODE_W-1:0] codeB,
  output logic              twoPhase
);
  localparam logic [CODE_W-1:0] MID_CODE = CODE_W'(1) << (CODE_W - 1);

  logic [POS_W-1:0]  posIdx, nextIdx, stride, lowMask, floorIdx, ceilIdx;
  logic [POS_W-1:0]  showIdx;
  logic [2:0]        shiftAmt;
  logic [1:0]        quad;
  logic [QUAD_W-1:0] sub;
  logic [CODE_W-1:0] riseMag, fallMag, magA, magB;
  stepMode_e         actMode;

  always_comb begin
    shiftAmt = strideShift(strb.mode);
    stride   = POS_W'(1) << shiftAmt;
    lowMask  = stride - 1'b1;
    floorIdx = posIdx & ~lowMask;
    ceilIdx  = (posIdx + lowMask) & ~lowMask;
    if (!strb.dirRev)                 nextIdx = floorIdx + stride;
    else if (strb.mode == MD_FULL_MID) nextIdx = floorIdx - stride;
    else                              nextIdx = ceilIdx - stride;
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      posIdx  <= '0;
      actMode <= MD_HALF;
    end else if (strb.stepEn) begin
      posIdx  <= nextIdx;
      actMode <= strb.mode;
    end
  end

  always_comb begin
    showIdx = posIdx;
    if (actMode == MD_FULL_MID)
      showIdx = {posIdx[POS_W-1 -: 2], 1'b1, {(QUAD_W-1){1'b0}}};
    quad    = showIdx[POS_W-1 -: 2];
    sub     = showIdx[QUAD_W-1:0];
    riseMag = CODE_W'(sub);
    fallMag = (sub == '0) ? '1 : CODE_W'(~sub + 1'b1);
    magA    = quad[0] ? riseMag : fallMag;
    magB    = quad[0] ? fallMag : riseMag;
    if (isMaxHold(actMode)) begin
      if (magA != '0) magA = '1;
      if (magB != '0) magB = '1;
    end
  end

  assign codeA    = magA;
  assign codeB    = magB;
  assign polA     = quad[1] ^ quad[0];
  assign polB     = quad[1];
  assign twoPhase = (magA == MID_CODE) && (magB == MID_CODE);

  // R2, R10: without a strobe nothing moves
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !strb.stepEn |=> ($stable(posIdx) && $stable(actMode)));
  // R4: every accepted step changes the position
  p_step_moves_r4: assert property (@(posedge clk) disable iff (rst)
    strb.stepEn |=> (posIdx != $past(posIdx)));
  // R9: the control never issues a strobe in standby
  p_no_standby_step_r9: assert property (@(posedge clk) disable iff (rst)
    strb.stepEn |-> (strb.mode != MD_STANDBY));
  // R5: a dead coil A pairs with a full coil B
  p_zero_pairs_full_r5: assert property (@(posedge clk) disable iff (rst)
    (codeA == '0) |-> (codeB == '1));
  // R8: the monitor never rises in a full-current pattern
  p_mon_not_max_r8: assert property (@(posedge clk) disable iff (rst)
    twoPhase |-> !isMaxHold(actMode));
endmodule

// File: rtl/step_translator.sv
module step_translator
  import stepx_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter bit MICRO_EN    = 1'b1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        stepIn,
  input  logic        dirIn,
  input  logic [2:0]  modeIn,
  output logic        polA,
  output logic [3:0]  codeA,
  output logic        polB,
  output logic [3:0]  codeB,
  output logic        twoPhase
);
  stepStrobe_t strb;

  stepx_ctrl #(
    .SYNC_STAGES(SYNC_STAGES),
    .MICRO_EN   (MICRO_EN)
  ) u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .stepIn(stepIn),
    .dirIn (dirIn),
    .modeIn(modeIn),
    .strb  (strb)
  );

  stepx_datapath u_dp (
    .clk     (clk),
    .rst     (rst),
    .strb    (strb),
    .polA    (polA),
    .codeA   (codeA),
    .polB    (polB),
    .codeB   (codeB),
    .twoPhase(twoPhase)
  );
endmodule

// File: tb/step_translator_bench.sv
module step_translator_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       stepIn = 1'b0, dirIn = 1'b0;
  logic [2:0] modeIn = 3'b010;
  logic       stepFh = 1'b0;
  logic [2:0] modeFh = 3'b010;
  logic       polA, polB, twoPhase, fPolA, fPolB, fTwo;
  logic [3:0] codeA, codeB, fCodeA, fCodeB;

  int checks = 0, fails = 0, cycle = 0;
  int mPos = 0, mMode = 2;
  bit finished = 1'b0;

  typedef struct {
    int          due;
    logic [10:0] exp;
    string       tag;
  } expItem_t;
  expItem_t sb[$];

  always #2 clk = ~clk;

  step_translator u_step_translator (
    .clk(clk), .rst(rst), .stepIn(stepIn), .dirIn(dirIn), .modeIn(modeIn),
    .polA(polA), .codeA(codeA), .polB(polB), .codeB(codeB), .twoPhase(twoPhase));

  step_translator #(.MICRO_EN(1'b0)) u_step_translator_fh (
    .clk(clk), .rst(rst), .stepIn(stepFh), .dirIn(1'b0), .modeIn(modeFh),
    .polA(fPolA), .codeA(fCodeA), .polB(fPolB), .codeB(fCodeB), .twoPhase(fTwo));

  function automatic logic [10:0] modelOut();
    int p, q, k, up, dn, a, b;
    p  = (mMode == 0) ? (mPos / 16) * 16 + 8 : mPos;
    q  = p / 16;
    k  = p % 16;
    up = k;
    dn = (k == 0) ? 15 : 16 - k;
    a  = (q % 2 == 1) ? up : dn;
    b  = (q % 2 == 1) ? dn : up;
    if (mMode == 1 || mMode == 3) begin
      if (a != 0) a = 15;
      if (b != 0) b = 15;
    end
    return {logic'(q == 1 || q == 2), 4'(a), logic'(q >= 2), 4'(b),
            logic'(a == 8 && b == 8)};
  endfunction

  function automatic void modelStep(int md, bit rev);
    int st;
    if (md == 7) return;
    st = (md <= 1) ? 16 : (md <= 3) ? 8 : (md == 4) ? 4 : (md == 5) ? 2 : 1;
    if (!rev)         mPos = (mPos / st) * st + st;
    else if (md == 0) mPos = (mPos / st) * st - st;
    else              mPos = ((mPos + st - 1) / st) * st - st;
    mPos  = (mPos + 64) % 64;
    mMode = md;
  endfunction

  function automatic void pushExp(string tag);
    expItem_t it;
    it.due = cycle + 1;
    it.exp = modelOut();
    it.tag = tag;
    sb.push_back(it);
  endfunction

  function automatic void compare(string tag, logic [10:0] act, logic [10:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endfunction

  // monitor: pops expectations when they fall due
  always @(negedge clk) begin
    cycle <= cycle + 1;
    while (sb.size() > 0 && sb[0].due <= cycle) begin
      compare(sb[0].tag, {polA, codeA, polB, codeB, twoPhase}, sb[0].exp);
      void'(sb.pop_front());
    end
  end

  task automatic doStep(input logic [2:0] md, input logic rev, input int hold,
                        input string tag);
    @(negedge clk);
    modeIn = md; dirIn = rev; stepIn = 1'b1;
    repeat (hold) @(negedge clk);
    stepIn = 1'b0;
    repeat (4) @(negedge clk);
    modelStep(int'(md), rev);
    pushExp(tag);
    repeat (2) @(negedge clk);
  endtask

  task automatic stepFhTask(input logic [2:0] md);
    @(negedge clk);
    modeFh = md; stepFh = 1'b1;
    repeat (4) @(negedge clk);
    stepFh = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    compare("R1 reset outputs", {polA, codeA, polB, codeB, twoPhase}, 11'b0_1111_0_0000_0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    pushExp("R1 home after release");
    repeat (2) @(negedge clk);

    doStep(3'b110, 1'b0, 4, "R5 R3 sixteenth fwd 1");
    doStep(3'b110, 1'b0, 4, "R5 sixteenth fwd 2");
    doStep(3'b110, 1'b0, 20, "R2 held high single move");

    @(negedge clk); modeIn = 3'b010; dirIn = 1'b1;
    repeat (8) @(negedge clk);
    pushExp("R10 mode change without edge");
    repeat (2) @(negedge clk);

    doStep(3'b010, 1'b0, 4, "R11 R8 half fwd round up");
    doStep(3'b010, 1'b1, 4, "R3 half rev");
    doStep(3'b010, 1'b1, 4, "R6 R3 rev wrap quadrant 3");
    doStep(3'b011, 1'b0, 4, "R7 half max wrap");
    doStep(3'b011, 1'b0, 4, "R7 R8 half max diag");
    doStep(3'b111, 1'b0, 4, "R9 standby edge dropped");
    doStep(3'b100, 1'b0, 4, "R4 quarter fwd");
    doStep(3'b000, 1'b0, 4, "R11 R6 centred full fwd");
    doStep(3'b000, 1'b1, 4, "R11 centred full rev");
    doStep(3'b000, 1'b1, 4, "R6 centred full rev wrap");
    doStep(3'b001, 1'b0, 4, "R7 full max fwd");
    doStep(3'b001, 1'b0, 4, "R6 R7 full max quadrant 1");
    doStep(3'b101, 1'b1, 4, "R4 eighth rev");
    doStep(3'b101, 1'b1, 4, "R4 R5 eighth rev 2");

    @(posedge clk); #1;
    rst = 1'b1;
    #0.5;
    compare("R1 async reset mid-run", {polA, codeA, polB, codeB, twoPhase}, 11'b0_1111_0_0000_0);
    mPos = 0; mMode = 2;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    stepFhTask(3'b100);
    compare("R12 fh quarter code is standby", {fPolA, fCodeA, fPolB, fCodeB, fTwo}, 11'b0_1111_0_0000_0);
    stepFhTask(3'b110);
    compare("R12 fh sixteenth code is standby", {fPolA, fCodeA, fPolB, fCodeB, fTwo}, 11'b0_1111_0_0000_0);
    stepFhTask(3'b010);
    compare("R12 fh half step moves", {fPolA, fCodeA, fPolB, fCodeB, fTwo}, 11'b0_1000_0_1000_1);

    repeat (4) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule